// File: doc/BRIEF.md
# Button-Set Time-of-Day Clock Controller

This block keeps the time of day as hours, minutes and seconds, each held as a pair of BCD digits. Four single-cycle button pulses control it. These pulses come from debouncing logic that sits outside the block. The mode button switches between Set and Run. In Set, the seconds are held at zero and two edit buttons step the hour and the minute. In Run, a one-second tick enable advances the time, and carries ripple from seconds into minutes and from minutes into hours.

A view button selects what the four output digits show. One view shows hours and minutes. The other shows the seconds, with the two upper digits blanked. A one-cycle update strobe marks every cycle in which the presented digits differ from the previous cycle. Downstream logic can use it to forward the time, for example over a serial link.

Top module: `rtc_button_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, the time is 00:00:00, `runMode` is 0 (Set), the hours-and-minutes view is selected, `dispDigits` is 16'h0000 and `updatePulse` is 0.
- R2: A `btnMode` pulse inverts `runMode` at the next clock edge. 1 means Run and 0 means Set.
- R3: In Set, each `btnHour` pulse adds one to the hour, wrapping from 23 to 00. Each `btnMin` pulse adds one to the minute, wrapping from 59 to 00. Neither wrap carries into another field.
- R4: In Run, `btnHour` and `btnMin` have no effect on the time.
- R5: In Set, `tickSec` is ignored and the seconds read 00. Any edge that leaves the block in Set clears the seconds to 00.
- R6: In Run, a `tickSec` pulse adds one second. Seconds 59 wrap to 00 and carry into the minutes. Minutes 59 wrap to 00 and carry into the hours. 23:59:59 rolls to 00:00:00.
- R7: A `tickSec` pulse in the same cycle as a `btnMode` pulse is discarded.
- R8: Each `btnView` pulse toggles the view. In the hours-and-minutes view, `dispDigits` = {hour tens, hour units, minute tens, minute units}, with bits [15:12] holding the hour tens. In the seconds view, bits [15:8] are 8'hFF (blank code 4'hF) and bits [7:0] = {second tens, second units}.
- R9: `updatePulse` is 1 in exactly those cycles where `dispDigits` differs from its value in the previous cycle.
- R10: Each non-blank digit is always in the range 0 to 9. Each field's value stays below its modulus.
- R11: Edit buttons act according to the mode held before the edge, so an edit pulse together with a `btnMode` pulse in Set still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickSec | input | 1 | One-second tick enable, one cycle wide |
| btnMode | input | 1 | Set/Run toggle pulse |
| btnHour | input | 1 | Hour advance pulse |
| btnMin | input | 1 | Minute advance pulse |
| btnView | input | 1 | View toggle pulse |
| dispDigits | output | 16 | Four BCD digits of the selected view |
| runMode | output | 1 | 1 = Run, 0 = Set |
| updatePulse | output | 1 | One-cycle strobe on any change of the shown digits |

## Verification
The bench builds the block with its default moduli: 24 hours, and 60 for both minutes and seconds. These are the values where the carry and wrap corners of real use occur. Because `tickSec` can be driven on every cycle, the 59-to-00 second carry, the hour carry and the full 23:59:59 roll all happen within a few thousand cycles. Presses repeated more than a full modulus reach every edit wrap. A long stretch of random, overlapping pulses then exercises coincident presses and ticks against the reference model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Digit code shown in the blanked positions of the seconds view
  localparam logic [3:0] BLANK_DIGIT = 4'hF;

  // Strobes from mode control to the time datapath
  typedef struct packed {
    logic advHour;   // edit step on hours (Set only)
    logic advMin;    // edit step on minutes (Set only)
    logic stepSec;   // counted second (Run only)
    logic holdSec;   // force seconds to zero
    logic viewSecs;  // current view: 1 = seconds
    logic viewFlip;  // view toggles at this edge
  } rtc_ctl_t;

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int MODULUS = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inc,
  input  logic       clr,
  output logic [3:0] tens,
  output logic [3:0] units,
  output logic [3:0] nextTens,
  output logic [3:0] nextUnits,
  output logic       wrap
);

  localparam logic [3:0] LAST_TENS  = 4'((MODULUS - 1) / 10);
  localparam logic [3:0] LAST_UNITS = 4'((MODULUS - 1) % 10);

  logic atMax;

  always_comb begin
    atMax     = (tens == LAST_TENS) && (units == LAST_UNITS);
    wrap      = inc && atMax && !clr;
    nextTens  = tens;
    nextUnits = units;
    if (clr) begin
      nextTens  = 4'd0;
      nextUnits = 4'd0;
    end else if (inc) begin
      if (atMax) begin
        nextTens  = 4'd0;
        nextUnits = 4'd0;
      end else if (units == 4'd9) begin
        nextTens  = tens + 4'd1;
        nextUnits = 4'd0;
      end else begin
        nextUnits = units + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tens  <= 4'd0;
      units <= 4'd0;
    end else begin
      tens  <= nextTens;
      units <= nextUnits;
    end
  end

  // R10: digits stay legal and below the modulus
  assert_digit_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    (units <= 4'd9) && ((int'(tens) * 10 + int'(units)) < MODULUS));

  // R6: a counted step from the last value lands on zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inc && atMax && !clr) |=> (tens == 4'd0 && units == 4'd0));

  // R5: a clear request leaves the field at zero
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (tens == 4'd0 && units == 4'd0));

endmodule

// File: rtl/rtc_mode_ctrl.sv
module rtc_mode_ctrl
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickSec,
  input  logic      btnMode,
  input  logic      btnHour,
  input  logic      btnMin,
  input  logic      btnView,
  output rtc_ctl_t  ctl,
  output logic      runMode
);

  logic viewSecs;
  logic nextRun;

  always_comb begin
    nextRun      = runMode ^ btnMode;
    ctl.advHour  = btnHour && !runMode;
    ctl.advMin   = btnMin && !runMode;
    ctl.stepSec  = tickSec && runMode && !btnMode;
    ctl.holdSec  = !nextRun;
    ctl.viewSecs = viewSecs;
    ctl.viewFlip = btnView;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runMode  <= 1'b0;
      viewSecs <= 1'b0;
    end else begin
      runMode  <= nextRun;
      viewSecs <= viewSecs ^ btnView;
    end
  end

  // R2: a mode pulse always flips the mode
  assert_mode_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    btnMode |=> (runMode != $past(runMode)));

  // R8: the view only moves on a view pulse
  assert_view_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    !btnView |=> $stable(viewSecs));

endmodule

// File: rtl/rtc_time_path.sv
module rtc_time_path
  import rtc_pkg::*;
#(
  parameter int HOUR_MOD = 24,
  parameter int MIN_MOD  = 60,
  parameter int SEC_MOD  = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  rtc_ctl_t    ctl,
  output logic [15:0] dispDigits,
  output logic        updatePulse
);

  logic [3:0] secT, secU, secTn, secUn;
  logic [3:0] minT, minU, minTn, minUn;
  logic [3:0] hrT, hrU, hrTn, hrUn;
  logic       secWrap, minWrap, hrWrap;
  logic       minInc, hrInc;
  logic [15:0] nextDisp;

  function automatic logic [15:0] formatView(
    input logic sv,
    input logic [3:0] hT, input logic [3:0] hU,
    input logic [3:0] mT, input logic [3:0] mU,
    input logic [3:0] sT, input logic [3:0] sU);
    formatView = sv ? {BLANK_DIGIT, BLANK_DIGIT, sT, sU} : {hT, hU, mT, mU};
  endfunction

  assign minInc = ctl.advMin || (ctl.stepSec && secWrap);
  assign hrInc  = ctl.advHour || (ctl.stepSec && minWrap);

  rtc_bcd_field #(.MODULUS(SEC_MOD)) secField (
    .clk(clk), .rstN(rstN), .inc(ctl.stepSec), .clr(ctl.holdSec),
    .tens(secT), .units(secU), .nextTens(secTn), .nextUnits(secUn), .wrap(secWrap));

  rtc_bcd_field #(.MODULUS(MIN_MOD)) minField (
    .clk(clk), .rstN(rstN), .inc(minInc), .clr(1'b0),
    .tens(minT), .units(minU), .nextTens(minTn), .nextUnits(minUn), .wrap(minWrap));

  rtc_bcd_field #(.MODULUS(HOUR_MOD)) hrField (
    .clk(clk), .rstN(rstN), .inc(hrInc), .clr(1'b0),
    .tens(hrT), .units(hrU), .nextTens(hrTn), .nextUnits(hrUn), .wrap(hrWrap));

  always_comb begin
    dispDigits = formatView(ctl.viewSecs, hrT, hrU, minT, minU, secT, secU);
    nextDisp   = formatView(ctl.viewSecs ^ ctl.viewFlip, hrTn, hrUn, minTn, minUn, secTn, secUn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updatePulse <= 1'b0;
    else       updatePulse <= (nextDisp != dispDigits);
  end

  // R9: the strobe marks exactly the cycles with new digits
  assert_pulse_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse == (dispDigits != $past(dispDigits)));

  // R5: with no counted second and no clear, seconds hold
  assert_sec_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stepSec && !ctl.holdSec) |=> $stable({secT, secU}));

  // R6: a carry out of the hours on a counted second is the midnight roll
  assert_day_roll_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hrWrap && ctl.stepSec) |=> ({hrT, hrU, minT, minU, secT, secU} == 24'h0));

  // R3: edit steps on the minutes never reach the hours
  assert_edit_no_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advMin && !ctl.advHour) |=> $stable({hrT, hrU}));

endmodule

// File: rtl/rtc_button_ctrl.sv
module rtc_button_ctrl #(
  parameter int HOUR_MOD = 24,
  parameter int MIN_MOD  = 60,
  parameter int SEC_MOD  = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickSec,
  input  logic        btnMode,
  input  logic        btnHour,
  input  logic        btnMin,
  input  logic        btnView,
  output logic [15:0] dispDigits,
  output logic        runMode,
  output logic        updatePulse
);

  rtc_pkg::rtc_ctl_t ctlBus;

  rtc_mode_ctrl modeCtrl (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .btnMode(btnMode),
    .btnHour(btnHour), .btnMin(btnMin), .btnView(btnView),
    .ctl(ctlBus), .runMode(runMode));

  rtc_time_path #(.HOUR_MOD(HOUR_MOD), .MIN_MOD(MIN_MOD), .SEC_MOD(SEC_MOD)) timePath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus),
    .dispDigits(dispDigits), .updatePulse(updatePulse));

  // R4: in Run with no tick, edit pulses leave the shown digits alone
  assert_run_edit_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && !tickSec && !btnView && !btnMode) |=> $stable(dispDigits));

endmodule

// File: tb/rtc_button_ctrl_test.sv
module rtc_button_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickSec = 1'b0, btnMode = 1'b0, btnHour = 1'b0, btnMin = 1'b0, btnView = 1'b0;
  logic [15:0] dispDigits;
  logic        runMode, updatePulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state
  int mHour = 0, mMin = 0, mSec = 0;
  bit mRun = 0, mView = 0, modelValid = 0, expPulse = 0;
  logic [15:0] prevDisp = 16'h0;

  always #4 clk = ~clk;   // 125 MHz

  rtc_button_ctrl uut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .btnMode(btnMode),
    .btnHour(btnHour), .btnMin(btnMin), .btnView(btnView),
    .dispDigits(dispDigits), .runMode(runMode), .updatePulse(updatePulse));

  function automatic logic [15:0] modelDisp();
    if (mView) return {8'hFF, 4'(mSec / 10), 4'(mSec % 10)};
    return {4'(mHour / 10), 4'(mHour % 10), 4'(mMin / 10), 4'(mMin % 10)};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mHour = 0; mMin = 0; mSec = 0; mRun = 0; mView = 0;
      expPulse = 0;
      prevDisp = modelDisp();
    end else begin
      bit nRun;
      logic [15:0] nd;
      nRun = mRun ^ btnMode;
      if (!mRun) begin
        if (btnHour) mHour = (mHour + 1) % 24;
        if (btnMin)  mMin  = (mMin + 1) % 60;
      end else if (tickSec && !btnMode) begin
        mSec++;
        if (mSec == 60) begin
          mSec = 0; mMin++;
          if (mMin == 60) begin mMin = 0; mHour = (mHour + 1) % 24; end
        end
      end
      if (!nRun) mSec = 0;
      mRun = nRun;
      if (btnView) mView = !mView;
      nd = modelDisp();
      expPulse = (nd != prevDisp);
      prevDisp = nd;
    end
    modelValid = 1;
  end

  function automatic bit digitOk(input logic [3:0] d, input bit blankOk);
    return (d <= 4'd9) || (blankOk && d == 4'hF);
  endfunction

  always @(negedge clk) begin
    if (modelValid) begin
      checks++;
      if (dispDigits !== modelDisp() || runMode !== mRun) begin
        fails++;
        $display("FAIL %s digits/mode actual %h/%b expected %h/%b at cycle %0d",
                 curReq, dispDigits, runMode, modelDisp(), mRun, cycles);
      end
      checks++;
      if (updatePulse !== expPulse) begin
        fails++;
        $display("FAIL R9 updatePulse actual %b expected %b at cycle %0d",
                 updatePulse, expPulse, cycles);
      end
      checks++;
      if (!(digitOk(dispDigits[15:12], 1) && digitOk(dispDigits[11:8], 1) &&
            digitOk(dispDigits[7:4], 0) && digitOk(dispDigits[3:0], 0))) begin
        fails++;
        $display("FAIL R10 digit range actual %h expected BCD digits", dispDigits);
      end
    end
  end

  task automatic drive(input bit m, input bit h, input bit n, input bit v, input bit t);
    @(negedge clk);
    btnMode = m; btnHour = h; btnMin = n; btnView = v; tickSec = t;
  endtask

  task automatic idle(input int count);
    for (int i = 0; i < count; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 190000) begin
      fails++;
      $display("FAIL R6 watchdog actual %0d cycles expected completion below 190000", cycles);
      summary();
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) @(negedge clk);
    checks++;
    if (dispDigits !== 16'h0000 || runMode !== 1'b0 || updatePulse !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual %h/%b/%b expected 0000/0/0", dispDigits, runMode, updatePulse);
    end
    rstN = 1'b1;
    idle(2);

    // R3: hour edits wrap 23 -> 00, minute edits wrap 59 -> 00 with no carry
    curReq = "R3";
    for (int i = 0; i < 25; i++) drive(0, 1, 0, 0, 0);
    idle(1);
    for (int i = 0; i < 61; i++) drive(0, 0, 1, 0, 0);
    idle(1);

    // R5: ticks ignored in Set
    curReq = "R5";
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 0, 1);

    // R8: seconds view and back
    curReq = "R8";
    drive(0, 0, 0, 1, 0); idle(2);
    drive(0, 0, 0, 1, 0); idle(1);

    // R3: bring the time to 23:58
    curReq = "R3";
    for (int i = 0; i < 22; i++) drive(0, 1, 0, 0, 0);
    for (int i = 0; i < 57; i++) drive(0, 0, 1, 0, 0);

    // R11: edit together with the mode press still counts (Set -> Run)
    curReq = "R11";
    drive(1, 0, 1, 0, 0);
    idle(1);

    // R4: edits ignored in Run
    curReq = "R4";
    drive(0, 1, 0, 0, 0); drive(0, 0, 1, 0, 0); drive(0, 1, 1, 0, 0); idle(1);

    // R6: carries and midnight roll, ticks every cycle
    curReq = "R6";
    for (int i = 0; i < 65; i++) drive(0, 0, 0, 0, 1);
    for (int i = 0; i < 3700; i++) drive(0, 0, 0, 0, (i % 3) != 0);

    // R7: tick coinciding with mode press is dropped; R5: entering Set clears seconds
    curReq = "R7";
    drive(1, 0, 0, 0, 1);
    curReq = "R5";
    idle(2);
    drive(0, 0, 0, 1, 0); idle(1);
    curReq = "R7";
    drive(1, 0, 0, 0, 1);
    for (int i = 0; i < 30; i++) drive(0, 0, 0, 0, 1);
    curReq = "R5";
    drive(1, 0, 0, 0, 0); idle(2);

    // mixed random stimulus across all behaviour
    curReq = "R6";
    for (int i = 0; i < 20000; i++)
      drive(($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
            ($urandom % 20) == 0, ($urandom % 2) == 0);
    idle(3);

    // R1: reset again mid-run
    curReq = "R1";
    @(negedge clk); rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(2);
    summary();
  end

endmodule